// File: doc/BRIEF.md
# Serial Pattern and Pulse-Timing Trigger

This block is the arm-and-fire trigger stage of a sampled logic-capture front end. It looks at one sampled digital input, plus a second sampled channel used only for delay measurement, once per system clock. When its selected condition is met it emits a single-cycle trigger strobe and latches a fired status. It then waits until software re-arms it or returns it to idle.

The unit has four modes, set by a 2-bit mode field:
- 0: free-run. It fires at once, with no condition checked.
- 1: pattern. It compares a serial bit sequence, with a programmable length and a don't-care mask, against the most recent samples.
- 2: width. It measures high or low pulses and compares the width with a threshold, in either direction.
- 3: delay. It times the gap from a transition on the primary channel to a transition on the second channel, and checks it against a minimum and a maximum.

Pulse widths and delays are counted in sample cycles by saturating counters. The comparison is made at the sample that closes the pulse or the delay. Configuration can be loaded only while the unit is idle.

Top module: `trig_unit`

## Requirements
- R1: After reset, `trig`, `armed` and `fired` are all 0 and the unit is idle.
- R2: `cfg_we` loads the configuration only while the unit is idle (neither armed nor fired). A write attempted while armed or fired has no effect on later behaviour.
- R3: In mode 0, a unit armed by `arm` at clock edge E0 drives `trig` high for exactly the one cycle after edge E1.
- R4: In mode 1, at each sample, the last L samples are compared with `cfg_pattern`. Pattern bit i is compared with the sample taken i cycles before the current one, and only where `cfg_mask` bit i is 1. The unit fires on the first sample at which all compared bits match and at least L samples have been taken since arming. `trig` is high in the cycle after that sample's edge.
- R5: The pattern length L is `cfg_len`, with 0 taken as 1 and values above the pattern width (32) taken as 32.
- R6: In mode 2, the active level is `cfg_pol` (1 = high pulses). A pulse counts only if an inactive sample was seen after arming and before the pulse. It is evaluated at its first inactive sample: with `cfg_longer`=1 the unit fires when the width N > `cfg_thresh`, and with `cfg_longer`=0 when N < `cfg_thresh`.
- R7: In mode 3, D is the number of samples from a `din` transition to a later `din_b` transition. The unit fires when D < `cfg_dmin` or D > `cfg_dmax`. A `din` and `din_b` transition in the same sample while no measurement is open gives D = 0.
- R8: In mode 3, a new `din` transition while a measurement is open, with no `din_b` transition in that sample, restarts the measurement from that transition.
- R9: The width and delay counters saturate at 2^COUNT_W-1. A longer pulse or delay is compared as that value.
- R10: After firing, `trig` stays low and `fired` stays high, whatever the inputs, until `arm` or `disarm`.
- R11: `disarm` returns the unit to idle from any state. `arm` while idle or fired starts a fresh qualification.
- R12: When `arm` and `disarm` are asserted in the same cycle, `disarm` takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load configuration (idle only) |
| cfg_mode | input | 2 | Mode: 0 free-run, 1 pattern, 2 width, 3 delay |
| cfg_pattern | input | PAT_W | Serial pattern, bit 0 = newest sample |
| cfg_mask | input | PAT_W | 1 = bit compared |
| cfg_len | input | LEN_W | Pattern length |
| cfg_pol | input | 1 | Width mode polarity, 1 = high pulses |
| cfg_longer | input | 1 | Width mode: 1 fire above threshold, 0 below |
| cfg_thresh | input | COUNT_W | Width threshold in samples |
| cfg_dmin | input | COUNT_W | Delay minimum in samples |
| cfg_dmax | input | COUNT_W | Delay maximum in samples |
| arm | input | 1 | Start qualification |
| disarm | input | 1 | Return to idle |
| din | input | 1 | Primary sampled channel |
| din_b | input | 1 | Second sampled channel (delay mode) |
| trig | output | 1 | Single-cycle trigger strobe |
| armed | output | 1 | Unit is armed |
| fired | output | 1 | Unit has fired |

## Verification
In delay mode, the opening transition on the primary channel and the closing transition on the second channel can fall in the same sample. The bench toggles both inputs in one cycle, once with a nonzero minimum and once with a zero minimum, and expects a fire only when a zero delay lies outside the limits. A second collision, `arm` together with `disarm`, is driven directly and must leave the unit idle. Sweeps over widths, delays and patterns use a small counter width, so that saturation falls inside the run and the expected values can be worked out arithmetically.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_PATTERN = 2'd1,
    MODE_WIDTH   = 2'd2,
    MODE_DELAY   = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } trig_state_e;
endpackage

// File: rtl/trig_pattern.sv
module trig_pattern #(
  parameter int PAT_W = 32,
  parameter int LEN_W = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             din,
  input  logic [PAT_W-1:0] pat,
  input  logic [PAT_W-1:0] mask,
  input  logic [LEN_W-1:0] len,
  output logic             hit
);
  logic [PAT_W-1:0] sh_q, sh_d, win, lmask;
  logic [LEN_W-1:0] fill_q, fill_d;
  logic [LEN_W:0]   fill_inc;
  logic             full;

  assign win      = {sh_q[PAT_W-2:0], din};
  assign fill_inc = {1'b0, fill_q} + {{LEN_W{1'b0}}, 1'b1};
  assign full     = fill_inc >= {1'b0, len};

  for (genvar i = 0; i < PAT_W; i++) begin : g_lmask
    assign lmask[i] = LEN_W'(i) < len;
  end

  assign hit = run && full && (((win ^ pat) & mask & lmask) == '0);

  always_comb begin
    sh_d   = sh_q;
    fill_d = fill_q;
    if (restart) begin
      fill_d = '0;
    end else if (run) begin
      sh_d   = win;
      fill_d = (fill_q == LEN_W'(PAT_W)) ? fill_q : fill_inc[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else begin
      sh_q   <= sh_d;
      fill_q <= fill_d;
    end
  end

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= LEN_W'(PAT_W)) else $error("fill count above pattern width");
endmodule

// File: rtl/trig_width.sv
module trig_width #(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic               din,
  input  logic               pol,
  input  logic               longer,
  input  logic [COUNT_W-1:0] thr,
  output logic               hit
);
  localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

  logic               active, started_q, started_d;
  logic [COUNT_W-1:0] cnt_q, cnt_d;

  assign active = (din == pol);
  assign hit = run && !active && (cnt_q != '0) &&
               (longer ? (cnt_q > thr) : (cnt_q < thr));

  always_comb begin
    started_d = started_q;
    cnt_d     = cnt_q;
    if (restart) begin
      started_d = 1'b0;
      cnt_d     = '0;
    end else if (run) begin
      if (!active) begin
        started_d = 1'b1;
        cnt_d     = '0;
      end else if (started_q) begin
        cnt_d = (cnt_q == MAXV) ? cnt_q : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      started_q <= started_d;
      cnt_q     <= cnt_d;
    end
  end

  assert_width_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active && cnt_q == MAXV) |=> cnt_q == MAXV) else $error("width counter wrapped");
  assert_width_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> started_q) else $error("pulse counted without leading idle");
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic               din_a,
  input  logic               din_b,
  input  logic [COUNT_W-1:0] dmin,
  input  logic [COUNT_W-1:0] dmax,
  output logic               hit
);
  localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

  logic               pa_q, pb_q, ea, eb;
  logic               open_q, open_d;
  logic [COUNT_W-1:0] dcnt_q, dcnt_d, meas;
  logic               close_open, close_zero;

  assign ea         = din_a ^ pa_q;
  assign eb         = din_b ^ pb_q;
  assign close_open = open_q && eb;
  assign close_zero = !open_q && ea && eb;
  assign meas       = close_open ? dcnt_q : '0;
  assign hit = run && (close_open || close_zero) && ((meas < dmin) || (meas > dmax));

  always_comb begin
    open_d = open_q;
    dcnt_d = dcnt_q;
    if (restart) begin
      open_d = 1'b0;
      dcnt_d = '0;
    end else if (run) begin
      if (close_open) begin
        open_d = 1'b0;
      end else if (ea) begin
        if (!eb) begin
          open_d = 1'b1;
          dcnt_d = COUNT_W'(1);
        end
      end else if (open_q) begin
        dcnt_d = (dcnt_q == MAXV) ? dcnt_q : dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      open_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      pa_q   <= din_a;
      pb_q   <= din_b;
      open_q <= open_d;
      dcnt_q <= dcnt_d;
    end
  end

  assert_delay_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && open_q && !ea && !eb && dcnt_q == MAXV) |=> dcnt_q == MAXV) else $error("delay counter wrapped");
  assert_delay_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> dcnt_q != '0) else $error("open measurement with zero count");
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int PAT_W   = 32,
  parameter int COUNT_W = 24,
  parameter int LEN_W   = $clog2(PAT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_mode,
  input  logic [PAT_W-1:0]   cfg_pattern,
  input  logic [PAT_W-1:0]   cfg_mask,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_pol,
  input  logic               cfg_longer,
  input  logic [COUNT_W-1:0] cfg_thresh,
  input  logic [COUNT_W-1:0] cfg_dmin,
  input  logic [COUNT_W-1:0] cfg_dmax,
  input  logic               arm,
  input  logic               disarm,
  input  logic               din,
  input  logic               din_b,
  output logic               trig,
  output logic               armed,
  output logic               fired
);
  trig_state_e        st_q, st_d;
  trig_mode_e         mode_q;
  logic [PAT_W-1:0]   pat_q, mask_q;
  logic [LEN_W-1:0]   len_q, len_in;
  logic               pol_q, longer_q;
  logic [COUNT_W-1:0] thr_q, dmin_q, dmax_q;
  logic               cfg_en, restart, fire, trig_q, trig_d;
  logic               run_pat, run_wid, run_dly, hit_pat, hit_wid, hit_dly;

  assign cfg_en = cfg_we && (st_q == ST_IDLE);
  assign len_in = (cfg_len == '0) ? LEN_W'(1) :
                  (cfg_len > LEN_W'(PAT_W)) ? LEN_W'(PAT_W) : cfg_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_FREE;
      pat_q    <= '0;
      mask_q   <= '0;
      len_q    <= LEN_W'(1);
      pol_q    <= 1'b1;
      longer_q <= 1'b1;
      thr_q    <= '0;
      dmin_q   <= '0;
      dmax_q   <= '0;
    end else if (cfg_en) begin
      mode_q   <= trig_mode_e'(cfg_mode);
      pat_q    <= cfg_pattern;
      mask_q   <= cfg_mask;
      len_q    <= len_in;
      pol_q    <= cfg_pol;
      longer_q <= cfg_longer;
      thr_q    <= cfg_thresh;
      dmin_q   <= cfg_dmin;
      dmax_q   <= cfg_dmax;
    end
  end

  assign run_pat = (st_q == ST_ARMED) && (mode_q == MODE_PATTERN);
  assign run_wid = (st_q == ST_ARMED) && (mode_q == MODE_WIDTH);
  assign run_dly = (st_q == ST_ARMED) && (mode_q == MODE_DELAY);

  trig_pattern #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_pattern (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run_pat), .din(din),
    .pat(pat_q), .mask(mask_q), .len(len_q), .hit(hit_pat));

  trig_width #(.COUNT_W(COUNT_W)) u_width (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run_wid), .din(din),
    .pol(pol_q), .longer(longer_q), .thr(thr_q), .hit(hit_wid));

  trig_delay #(.COUNT_W(COUNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run_dly), .din_a(din),
    .din_b(din_b), .dmin(dmin_q), .dmax(dmax_q), .hit(hit_dly));

  always_comb begin
    fire = 1'b0;
    if (st_q == ST_ARMED) begin
      case (mode_q)
        MODE_FREE:    fire = 1'b1;
        MODE_PATTERN: fire = hit_pat;
        MODE_WIDTH:   fire = hit_wid;
        MODE_DELAY:   fire = hit_dly;
        default:      fire = 1'b0;
      endcase
    end
  end

  always_comb begin
    st_d    = st_q;
    restart = 1'b0;
    trig_d  = 1'b0;
    if (disarm) begin
      st_d = ST_IDLE;
    end else if (arm && st_q != ST_ARMED) begin
      st_d    = ST_ARMED;
      restart = 1'b1;
    end else if (fire) begin
      st_d   = ST_FIRED;
      trig_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      trig_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      trig_q <= trig_d;
    end
  end

  assign trig  = trig_q;
  assign armed = (st_q == ST_ARMED);
  assign fired = (st_q == ST_FIRED);

  assert_trig_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q) else $error("trigger longer than one cycle");
  assert_trig_fired_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> st_q == ST_FIRED) else $error("trigger without fired state");
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(mode_q) && $stable(pat_q) && $stable(thr_q) && $stable(dmin_q)))
    else $error("configuration changed outside idle");
  assert_free_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && mode_q == MODE_FREE && !disarm) |=> trig_q) else $error("free-run did not fire");
  assert_disarm_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> st_q == ST_IDLE) else $error("disarm ignored");
endmodule

// File: tb/trig_unit_tb.sv
`timescale 1ns/1ps
module trig_unit_tb;
  localparam int PW = 32;
  localparam int CW = 6;
  localparam int LW = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_pol, cfg_longer, arm, disarm, din, din_b;
  logic [1:0] cfg_mode;
  logic [PW-1:0] cfg_pattern, cfg_mask;
  logic [LW-1:0] cfg_len;
  logic [CW-1:0] cfg_thresh, cfg_dmin, cfg_dmax;
  logic trig, armed, fired;
  int checks = 0;
  int failures = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  trig_unit #(.PAT_W(PW), .COUNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask), .cfg_len(cfg_len),
    .cfg_pol(cfg_pol), .cfg_longer(cfg_longer), .cfg_thresh(cfg_thresh),
    .cfg_dmin(cfg_dmin), .cfg_dmax(cfg_dmax), .arm(arm), .disarm(disarm),
    .din(din), .din_b(din_b), .trig(trig), .armed(armed), .fired(fired));

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  task automatic go_idle;
    disarm = 1'b1; step; disarm = 1'b0;
  endtask

  task automatic do_arm;
    arm = 1'b1; step; arm = 1'b0;
  endtask

  task automatic write_cfg(int mode, logic [PW-1:0] pat, logic [PW-1:0] msk, int len,
                           int pol, int longer, int thr, int dmn, int dmx);
    cfg_mode = 2'(mode); cfg_pattern = pat; cfg_mask = msk; cfg_len = LW'(len);
    cfg_pol = 1'(pol); cfg_longer = 1'(longer); cfg_thresh = CW'(thr);
    cfg_dmin = CW'(dmn); cfg_dmax = CW'(dmx);
    cfg_we = 1'b1; step; cfg_we = 1'b0;
  endtask

  task automatic run_pat(int len, logic [PW-1:0] pat, logic [PW-1:0] msk, int prefix);
    int eff;
    logic [63:0] lm;
    logic [PW-1:0] hist;
    int n;
    bit done, b, exp;
    eff = (len == 0) ? 1 : (len > PW ? PW : len);
    lm = (64'd1 << eff) - 64'd1;
    go_idle;
    write_cfg(1, pat, msk, len, 1, 1, 0, 0, 0);
    do_arm;
    check("R4 armed after arm", armed, 1);
    hist = '0; n = 0; done = 0;
    for (int k = 0; k < prefix + eff + 4; k++) begin
      if (k >= prefix && k < prefix + eff) b = pat[eff - 1 - (k - prefix)];
      else b = next_bit();
      din = b;
      step;
      hist = {hist[PW-2:0], b};
      n++;
      exp = !done && (n >= eff) && ((((hist ^ pat) & msk) & lm[PW-1:0]) == '0);
      check(eff != len ? "R5 pattern len clamp" : (done ? "R10 no refire" : "R4 pattern"), trig, exp);
      if (exp) begin
        check("R10 fired status", fired, 1);
        done = 1;
      end
    end
    check("R4 pattern seen", done, 1);
  endtask

  task automatic run_width(int pol, int longer, int thr, int n);
    int meas;
    bit exp;
    meas = (n > MAXC) ? MAXC : n;
    exp = longer ? (meas > thr) : (meas < thr);
    go_idle;
    din = 1'(!pol);
    write_cfg(2, '0, '0, 1, pol, longer, thr, 0, 0);
    do_arm;
    step;
    for (int k = 0; k < n; k++) begin
      din = 1'(pol); step;
      if (k == 0 || k == n - 1) check("R6 width open", trig, 0);
    end
    din = 1'(!pol); step;
    check(n > MAXC ? "R9 width saturation" : "R6 width compare", trig, exp);
    step;
    check("R10 width after", trig, 0);
    check("R6 armed left", armed, exp ? 0 : 1);
  endtask

  task automatic run_delay(int d, int dmn, int dmx);
    int meas;
    bit exp;
    meas = (d > MAXC) ? MAXC : d;
    exp = (meas < dmn) || (meas > dmx);
    go_idle;
    din = 1'b0; din_b = 1'b0;
    write_cfg(3, '0, '0, 1, 1, 1, 0, dmn, dmx);
    step;
    do_arm;
    step;
    check("R7 delay idle", trig, 0);
    if (d == 0) begin
      din = 1'b1; din_b = 1'b1; step;
    end else begin
      din = 1'b1; step;
      check("R7 delay open", trig, 0);
      for (int k = 1; k < d; k++) step;
      din_b = 1'b1; step;
    end
    check(d > MAXC ? "R9 delay saturation" : "R7 delay compare", trig, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_mode = 0; cfg_pattern = 0; cfg_mask = 0; cfg_len = 0;
    cfg_pol = 0; cfg_longer = 0; cfg_thresh = 0; cfg_dmin = 0; cfg_dmax = 0;
    arm = 0; disarm = 0; din = 0; din_b = 0;
    repeat (3) step;
    rst_n = 1'b1;
    step;
    check("R1 trig reset", trig, 0);
    check("R1 armed reset", armed, 0);
    check("R1 fired reset", fired, 0);

    // R3 free-run, then R11 re-arm from fired and R2 write ignored while fired
    write_cfg(0, '0, '0, 1, 1, 1, 0, 0, 0);
    do_arm;
    check("R3 armed", armed, 1);
    check("R3 no trig yet", trig, 0);
    step;
    check("R3 free-run trig", trig, 1);
    check("R3 fired", fired, 1);
    step;
    check("R10 single pulse", trig, 0);
    check("R10 stays fired", fired, 1);
    write_cfg(1, '1, '1, 8, 1, 1, 0, 0, 0);
    din = 0;
    check("R2 still fired", fired, 1);
    do_arm;
    step;
    check("R11 rearm from fired", trig, 1);
    check("R2 write ignored when fired", fired, 1);

    // R2 write ignored while armed
    go_idle;
    write_cfg(1, '1, '1, 8, 1, 1, 0, 0, 0);
    do_arm;
    cfg_mode = 2'd0; cfg_we = 1'b1; step; cfg_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step;
      check("R2 write ignored when armed", trig, 0);
    end
    check("R2 still armed", armed, 1);
    go_idle;
    check("R11 disarm to idle", armed, 0);

    // R12
    write_cfg(0, '0, '0, 1, 1, 1, 0, 0, 0);
    arm = 1'b1; disarm = 1'b1; step; arm = 1'b0; disarm = 1'b0;
    check("R12 disarm wins armed", armed, 0);
    step;
    check("R12 disarm wins trig", trig, 0);

    // R4/R5 pattern sweep
    run_pat(10, 32'b0111001101, '1, 20);
    run_pat(10, 32'b0111001101, 32'h3F0, 15);
    for (int l = 1; l <= 6; l++) run_pat(l, {lfsr[15:0], lfsr[31:16]}, '1, 8);
    run_pat(17, lfsr ^ 32'h5A5A_0F0F, '1, 12);
    run_pat(32, lfsr ^ 32'h1234_ABCD, '1, 40);
    run_pat(32, 32'hFFFF_0000, 32'h00FF_FF00, 10);
    run_pat(0, 32'h1, '1, 5);
    run_pat(40, 32'hC3A5_96E1, '1, 10);

    // R6 width sweep
    for (int p = 0; p < 2; p++)
      for (int lg = 0; lg < 2; lg++)
        for (int n = 1; n <= 8; n++) run_width(p, lg, 4, n);
    run_width(1, 1, MAXC - 1, 70);
    run_width(1, 1, MAXC, 70);
    run_width(0, 1, MAXC, 70);

    // R6 pulse already active at arm is not counted
    go_idle;
    din = 1'b1;
    write_cfg(2, '0, '0, 1, 1, 0, 10, 0, 0);
    do_arm;
    for (int k = 0; k < 3; k++) begin step; check("R6 leading pulse ignored", trig, 0); end
    din = 1'b0; step;
    check("R6 partial pulse not counted", trig, 0);
    din = 1'b1; step; step;
    din = 1'b0; step;
    check("R6 qualified short pulse", trig, 1);

    // R7 delay sweep including coincident transitions
    for (int d = 0; d <= 10; d++) run_delay(d, 3, 6);
    run_delay(0, 0, 6);
    run_delay(70, 0, MAXC - 1);
    run_delay(70, 0, MAXC);

    // R8 restart on second primary transition: D from second is 4 (in range)
    go_idle;
    din = 1'b0; din_b = 1'b0;
    write_cfg(3, '0, '0, 1, 1, 1, 0, 3, 6);
    step;
    do_arm;
    din = 1'b1; step;
    step; step;
    din = 1'b0; step;
    check("R8 restart open", trig, 0);
    step; step; step;
    din_b = 1'b1; step;
    check("R8 restart measured", trig, 0);
    check("R8 still armed", armed, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule